// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block decodes the bus write cycles sent to a byte-wide NOR flash controller model. Each write-valid pulse carries an address and a data byte. The decoder uses single-cycle command bytes to choose what later reads return: array data, identifier data or the status byte. It also recognises two-cycle setup/confirm sequences for erase, program and lock operations. When a sequence is confirmed, it sends a one-cycle start request to the operation sequencer. The request carries the operation type, the confirm-cycle address and the confirm-cycle data.

The decoder holds the sticky error bits of the status byte. These bits record a malformed confirm, a low supply and a blocked target. They stay set until the clear command is written. The ready bit and the suspended bit of the status byte come straight from the sequencer. Supply level and write protection arrive as plain input flags that are sampled at the confirm cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_mode is 0 (array), status is 80h with seq_busy and seq_susp low, and op_start is low.
- R2: When idle, a write of FFh sets rd_mode to 0, 90h sets it to 1 (identifier) and 70h sets it to 2 (status). The new rd_mode is visible in the cycle after the write.
- R3: A write of FFh while seq_busy is high and seq_susp is low leaves rd_mode unchanged.
- R4: 20h followed by D0h pulses op_start for one cycle with op_type 1 (block erase) and op_addr equal to the confirm address. 30h followed by D0h gives op_type 2 (chip erase).
- R5: 40h or 10h followed by any byte gives op_type 3 (program) with op_addr and op_data taken from the second write. No error bit is set.
- R6: 60h followed by 01h gives op_type 4 (set block lock). 60h followed by D0h gives op_type 5 (clear all locks). 60h followed by F1h gives op_type 6 (set permanent lock).
- R7: Any other second byte after 20h, 30h or 60h sets status bits 5 and 4 and issues no start.
- R8: At a valid confirm, if supply_ok is low, status bit 3 is set together with the class bit and no start is issued. Otherwise, if target_locked is high, status bit 1 is set together with the class bit and no start is issued. The class bit is bit 5 for op_types 1, 2 and 5, and bit 4 for op_types 3, 4 and 6.
- R9: Status bits 5, 4, 3 and 1 stay set until an idle write of 50h clears them all. While seq_susp is high, 50h leaves them unchanged.
- R10: A setup byte (20h, 30h, 40h, 10h, 60h) sets rd_mode to 2, and so does every second cycle of a sequence. The mode stays 2 until another single-cycle mode command is written.
- R11: Status bit 7 equals not seq_busy and bit 6 equals seq_susp, in the same cycle. Bits 2 and 0 read 0.
- R12: When idle, any other byte leaves rd_mode, the status byte and the sequence state unchanged. For example, 50h followed by D0h issues no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle bus write pulse |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data / command byte |
| seq_busy | input | 1 | Sequencer running an operation |
| seq_susp | input | 1 | Sequencer operation suspended |
| supply_ok | input | 1 | Programming supply adequate |
| target_locked | input | 1 | Target protected by lock or write-protect |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 status |
| status | output | 8 | Status byte |
| op_start | output | 1 | One-cycle start request |
| op_type | output | 3 | Operation type of the request |
| op_addr | output | AW | Operation address |
| op_data | output | 8 | Operation data |

## Verification
Every registered result of a write appears exactly one cycle after the write pulse: rd_mode, the sticky error bits and the op_start pulse with its fields. Status bits 7 and 6 follow the sequencer inputs with no delay. The bench drives each write at a falling edge and drops it at the next falling edge. It then compares all outputs against a bench model of the sequence state, the mode and the error bits. That sample point lands inside the single cycle in which op_start is high. Directed sequences cover each command, each error encoding and the cases that are ignored. Seeded random bytes, drawn mostly from the command set and combined with random sequencer and supply flags, then exercise interleavings.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          seq_busy,
  input  logic          seq_susp,
  input  logic          supply_ok,
  input  logic          target_locked,
  output logic [1:0]    rd_mode,
  output logic [7:0]    status,
  output logic          op_start,
  output logic [2:0]    op_type,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_ST = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_CHIP, S_PROG, S_LOCK} st_t;

  st_t        st;
  logic [3:0] err;
  logic [2:0] cfm_type;
  logic       cfm_ok, cls_erase, clr_req;

  always_comb begin
    cfm_type = 3'd0;
    case (st)
      S_ERASE: if (wr_data == 8'hD0) cfm_type = 3'd1;
      S_CHIP:  if (wr_data == 8'hD0) cfm_type = 3'd2;
      S_PROG:  cfm_type = 3'd3;
      S_LOCK:  case (wr_data)
                 8'h01:   cfm_type = 3'd4;
                 8'hD0:   cfm_type = 3'd5;
                 8'hF1:   cfm_type = 3'd6;
                 default: cfm_type = 3'd0;
               endcase
      default: cfm_type = 3'd0;
    endcase
  end

  assign cfm_ok    = cfm_type != 3'd0;
  assign cls_erase = (cfm_type == 3'd1) || (cfm_type == 3'd2) || (cfm_type == 3'd5);
  assign clr_req   = wr_valid && st == S_IDLE && wr_data == 8'h50 && !seq_susp;

  assign status = {~seq_busy, seq_susp, err[3], err[2], err[1], 1'b0, err[0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd_mode  <= M_ARR;
      err      <= '0;
      op_start <= 1'b0;
      op_type  <= '0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= 1'b0;
      if (wr_valid) begin
        if (st == S_IDLE) begin
          case (wr_data)
            8'hFF: if (!(seq_busy && !seq_susp)) rd_mode <= M_ARR;
            8'h90: rd_mode <= M_ID;
            8'h70: rd_mode <= M_ST;
            8'h50: if (!seq_susp) err <= '0;
            8'h20: begin st <= S_ERASE; rd_mode <= M_ST; end
            8'h30: begin st <= S_CHIP;  rd_mode <= M_ST; end
            8'h40, 8'h10: begin st <= S_PROG; rd_mode <= M_ST; end
            8'h60: begin st <= S_LOCK;  rd_mode <= M_ST; end
            default: ;
          endcase
        end else begin
          st      <= S_IDLE;
          rd_mode <= M_ST;
          if (!cfm_ok) begin
            err[3] <= 1'b1;
            err[2] <= 1'b1;
          end else if (!supply_ok) begin
            err[1] <= 1'b1;
            if (cls_erase) err[3] <= 1'b1; else err[2] <= 1'b1;
          end else if (target_locked) begin
            err[0] <= 1'b1;
            if (cls_erase) err[3] <= 1'b1; else err[2] <= 1'b1;
          end else begin
            op_start <= 1'b1;
            op_type  <= cfm_type;
            op_addr  <= wr_addr;
            op_data  <= wr_data;
          end
        end
      end
    end
  end

  p_start_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_start_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> rd_mode == M_ST);

  p_ff_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && st == S_IDLE && wr_data == 8'hFF && seq_busy && !seq_susp)
    |=> rd_mode == $past(rd_mode));

  p_bad_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (st == S_ERASE || st == S_CHIP || st == S_LOCK) && !cfm_ok)
    |=> (status[5] && status[4] && !op_start));

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && status[3]) |=> status[3]);

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2] && !status[0]);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic seq_busy = 0, seq_susp = 0, supply_ok = 1, target_locked = 0;
  logic [1:0] rd_mode;
  logic [7:0] status;
  logic op_start;
  logic [2:0] op_type;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;

  int checks = 0, fails = 0, cyc = 0;
  int est = 0, emode = 0;
  logic [3:0] eerr = '0;
  logic estart = 0;
  logic [2:0] etype = '0;
  logic [AW-1:0] eaddr = '0;
  logic [7:0] edata = '0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [2:0] f_type(int s, logic [7:0] d);
    case (s)
      1: return (d == 8'hD0) ? 3'd1 : 3'd0;
      2: return (d == 8'hD0) ? 3'd2 : 3'd0;
      3: return 3'd3;
      4: return (d == 8'h01) ? 3'd4 : (d == 8'hD0) ? 3'd5 : (d == 8'hF1) ? 3'd6 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] f_status();
    return {~seq_busy, seq_susp, eerr[3], eerr[2], eerr[1], 1'b0, eerr[0], 1'b0};
  endfunction

  task automatic model(logic [AW-1:0] a, logic [7:0] d);
    logic [2:0] t;
    logic ce;
    estart = 0;
    if (est == 0) begin
      case (d)
        8'hFF: if (!(seq_busy && !seq_susp)) emode = 0;
        8'h90: emode = 1;
        8'h70: emode = 2;
        8'h50: if (!seq_susp) eerr = 0;
        8'h20: begin est = 1; emode = 2; end
        8'h30: begin est = 2; emode = 2; end
        8'h40, 8'h10: begin est = 3; emode = 2; end
        8'h60: begin est = 4; emode = 2; end
        default: ;
      endcase
    end else begin
      t = f_type(est, d);
      ce = (t == 1 || t == 2 || t == 5);
      est = 0; emode = 2;
      if (t == 0) eerr[3:2] = 2'b11;
      else if (!supply_ok) begin eerr[1] = 1; if (ce) eerr[3] = 1; else eerr[2] = 1; end
      else if (target_locked) begin eerr[0] = 1; if (ce) eerr[3] = 1; else eerr[2] = 1; end
      else begin estart = 1; etype = t; eaddr = a; edata = d; end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " mode"}, rd_mode, emode);
    chk({tag, " status"}, status, f_status());
    chk({tag, " start"}, op_start, estart);
    if (estart) begin
      chk({tag, " type"}, op_type, etype);
      chk({tag, " addr"}, op_addr, eaddr);
      chk({tag, " data"}, op_data, edata);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    model(a, d);
    @(negedge clk);
    wr_valid = 0;
    check_all(tag);
  endtask

  initial begin
    int r;
    logic [7:0] cmds [14] = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'h30, 8'h40,
                              8'h10, 8'h60, 8'hD0, 8'h01, 8'hF1, 8'hB0, 8'h00};
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    wr('h10, 8'h90, "R2");
    wr('h10, 8'h70, "R2");
    wr('h10, 8'hFF, "R2");
    wr('h0, 8'h20, "R10");
    wr('h12345, 8'hD0, "R4");
    wr('h0, 8'h30, "R4");
    wr('h0, 8'hD0, "R4");
    wr('h0, 8'h40, "R5");
    wr('hABCDE, 8'h50, "R5");
    wr('h0, 8'h10, "R5");
    wr('h00777, 8'hD0, "R5");
    wr('h0, 8'h60, "R6"); wr('h20000, 8'h01, "R6");
    wr('h0, 8'h60, "R6"); wr('h0, 8'hD0, "R6");
    wr('h0, 8'h60, "R6"); wr('h0, 8'hF1, "R6");
    wr('h0, 8'h20, "R7"); wr('h0, 8'h33, "R7");
    seq_susp = 1;
    wr('h0, 8'h50, "R9");
    seq_susp = 0;
    wr('h0, 8'h50, "R9");
    wr('h0, 8'h60, "R7"); wr('h0, 8'h77, "R7");
    wr('h0, 8'h50, "R9");
    supply_ok = 0; target_locked = 1;
    wr('h0, 8'h20, "R8"); wr('h0, 8'hD0, "R8");
    supply_ok = 1;
    wr('h0, 8'h40, "R8"); wr('h5, 8'h12, "R8");
    target_locked = 0;
    wr('h0, 8'h50, "R9");
    wr('h0, 8'hFF, "R2");
    seq_busy = 1;
    wr('h0, 8'h90, "R3");
    wr('h0, 8'hFF, "R3");
    seq_susp = 1;
    wr('h0, 8'hFF, "R3");
    check_all("R11");
    seq_busy = 0; seq_susp = 0;
    wr('h0, 8'h90, "R12");
    wr('h0, 8'hB0, "R12");
    wr('h0, 8'hD0, "R12");
    wr('h0, 8'h50, "R12"); wr('h0, 8'hD0, "R12");
    for (int i = 0; i < 400; i++) begin
      seq_busy      = ($urandom % 2) == 0;
      seq_susp      = ($urandom % 5) == 0;
      supply_ok     = ($urandom % 6) != 0;
      target_locked = ($urandom % 6) == 0;
      if ($urandom % 8 == 0) wr($urandom, 8'($urandom), "RND");
      else wr($urandom, cmds[$urandom % 14], "RND");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule